// File: doc/BRIEF.md
# Fixed-Point Requantizer

This stage shrinks a signed two's complement sample from a wide format to a narrower one, as done after a multiply or accumulate step in a datapath. It works in two steps. First, a fixed number of low-order bits is discarded, either by plain flooring or by rounding. Rounding can take exact halves away from zero, or to the nearest even result so that no DC or power bias builds up. Second, surplus high-order bits are removed, either by simply dropping them (wrapping) or by saturating to the output's extreme values.

The widths, the count of discarded low bits, the rounding method and the high-bit method are all elaboration-time parameters, so one build instantiates one fixed behaviour. Samples enter with a valid strobe and leave one clock later with their own valid strobe and an overflow flag. The flag reports that the high-bit step altered the value.

Top module: `fxp_requant`

## Requirements
- R1: Each accepted input sample (in_vld high at a rising edge) appears on out_data with out_vld high exactly one clock later; out_vld is low in every other cycle.
- R2: In floor mode the result before high-bit reduction equals the input shifted arithmetically right by DROP_LSB, e.g. -5 with two bits dropped gives -2.
- R3: In half-away mode, fractions above one half round up, fractions below round down, and an exact half moves away from zero (-1.5 to -2, 2.5 to 3).
- R4: In half-even mode, fractions other than one half round to the nearest value, and an exact half goes to the nearest even integer (-1.5 to -2, -0.5 to 0, 0.5 to 0, 1.5 to 2, 2.5 to 2).
- R5: In wrap mode the output holds the low OUT_W bits of the rounded value, so an out-of-range value wraps around (7 plus one in 4 bits gives -8).
- R6: In clip mode a rounded value above the output range gives the most positive code, and one below gives the most negative code.
- R7: out_ovf is high, together with out_vld, exactly when the rounded value lies outside the signed OUT_W range, in both high-bit modes; it is never high while out_vld is low.
- R8: Rounding is done at full precision before high-bit reduction, so a round-up that leaves the output range (the largest input rounding up) is then clipped or wrapped and flagged.
- R9: While rst_n is low, out_vld, out_ovf and out_data are all driven to zero from the next rising edge.
- R10: When no sample is accepted, out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | IN_W | Input sample, signed two's complement |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Output sample, signed two's complement |
| out_ovf | output | 1 | High-bit reduction changed the value |

## Verification
The properties rely on rst_n being driven synchronously and on in_vld being a clean level at every edge; in_data may take any value. The stimulus changes inputs just after a rising edge. It sweeps every input code, with idle gaps so that the hold behaviour is exercised. Directed values land on exact halves of both signs and on codes at the limits of the output range, including the largest input, which rounds past the top.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;

   typedef enum logic [1:0] {
      RND_FLOOR,
      RND_HALF_AWAY,
      RND_HALF_EVEN
   } rnd_mode_e;

   typedef enum logic {
      MSB_WRAP,
      MSB_CLIP
   } msb_mode_e;

endpackage

// File: rtl/fxp_lsb_round.sv
module fxp_lsb_round
   import fxp_requant_pkg::*;
#(
   parameter int        IN_W  = 16,
   parameter int        DROP  = 4,
   parameter rnd_mode_e MODE  = RND_HALF_EVEN,
   localparam int       Q_W   = IN_W - DROP,
   localparam int       MID_W = Q_W + 1
) (
   input  logic [IN_W-1:0]  din,
   output logic [MID_W-1:0] dout
);

   generate
      if (DROP == 0) begin : g_pass
         assign dout = {din[IN_W-1], din};
      end else begin : g_round
         logic [Q_W-1:0] quo;
         logic           half;
         logic           rest;
         logic           up;

         assign quo  = din[IN_W-1:DROP];
         assign half = din[DROP-1];

         if (DROP > 1) begin : g_rest
            assign rest = |din[DROP-2:0];
         end else begin : g_norest
            assign rest = 1'b0;
         end

         case (MODE)
            RND_HALF_AWAY: begin : g_away
               // exact half of a negative value keeps the floor (away from zero)
               assign up = half & (rest | ~din[IN_W-1]);
            end
            RND_HALF_EVEN: begin : g_even
               // exact half moves up only from an odd floor
               assign up = half & (rest | quo[0]);
            end
            default: begin : g_floor
               assign up = 1'b0 & half & rest;
            end
         endcase

         assign dout = {quo[Q_W-1], quo} + {{(MID_W-1){1'b0}}, up};
      end
   endgenerate

endmodule

// File: rtl/fxp_msb_reduce.sv
module fxp_msb_reduce
   import fxp_requant_pkg::*;
#(
   parameter int        MID_W = 13,
   parameter int        OUT_W = 8,
   parameter msb_mode_e MODE  = MSB_CLIP,
   localparam int       TOP_W = MID_W - OUT_W + 1
) (
   input  logic [MID_W-1:0] din,
   output logic [OUT_W-1:0] dout,
   output logic             ovf
);

   logic [TOP_W-1:0] top;
   logic             fits;

   assign top  = din[MID_W-1:OUT_W-1];
   assign fits = (top == '0) | (top == '1);
   assign ovf  = ~fits;

   generate
      if (MODE == MSB_CLIP) begin : g_clip
         logic [OUT_W-1:0] lim;
         assign lim  = din[MID_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                    : {1'b0, {(OUT_W-1){1'b1}}};
         assign dout = fits ? din[OUT_W-1:0] : lim;
      end else begin : g_wrap
         assign dout = din[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
   import fxp_requant_pkg::*;
#(
   parameter int        IN_W     = 16,
   parameter int        OUT_W    = 8,
   parameter int        DROP_LSB = 4,
   parameter rnd_mode_e RND_MODE = RND_HALF_EVEN,
   parameter msb_mode_e MSB_MODE = MSB_CLIP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_vld,
   output logic [OUT_W-1:0] out_data,
   output logic             out_ovf
);

   localparam int MID_W = IN_W - DROP_LSB + 1;

   generate
      if (DROP_LSB < 0 || DROP_LSB >= IN_W) begin : g_bad_drop
         $error("fxp_requant: DROP_LSB must lie in 0..IN_W-1");
      end
      if (OUT_W < 2 || OUT_W > IN_W - DROP_LSB) begin : g_bad_out
         $error("fxp_requant: OUT_W must lie in 2..IN_W-DROP_LSB");
      end
   endgenerate

   logic [MID_W-1:0] rnd_val;
   logic [OUT_W-1:0] red_val;
   logic             red_ovf;

   fxp_lsb_round #(
      .IN_W (IN_W),
      .DROP (DROP_LSB),
      .MODE (RND_MODE)
   ) u_lsb (
      .din  (in_data),
      .dout (rnd_val)
   );

   fxp_msb_reduce #(
      .MID_W (MID_W),
      .OUT_W (OUT_W),
      .MODE  (MSB_MODE)
   ) u_msb (
      .din  (rnd_val),
      .dout (red_val),
      .ovf  (red_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_ovf  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= in_vld;
         out_ovf <= in_vld & red_ovf;
         if (in_vld) begin
            out_data <= red_val;
         end
      end
   end

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk
   import fxp_requant_pkg::*;
#(
   parameter int        OUT_W    = 8,
   parameter msb_mode_e MSB_MODE = MSB_CLIP
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic             out_vld,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf
);

   localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

   // R1
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R1
   vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);

   // R7
   ovf_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_vld);

   // R10
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_data));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_vld && !out_ovf && out_data == '0));

   generate
      if (MSB_MODE == MSB_CLIP) begin : g_clip_chk
         // R6
         clip_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_ovf |-> (out_data == MAX_CODE || out_data == MIN_CODE));
      end
   endgenerate

endmodule

bind fxp_requant fxp_requant_chk #(
   .OUT_W    (OUT_W),
   .MSB_MODE (MSB_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .out_vld  (out_vld),
   .out_data (out_data),
   .out_ovf  (out_ovf)
);

// File: tb/fxp_requant_tb.sv
module fxp_requant_tb;
   import fxp_requant_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int IN_W  = 10;
   localparam int OUT_W = 4;
   localparam int DROP  = 3;
   localparam int NDUT  = 3;

   typedef struct {
      logic [OUT_W-1:0] data;
      logic             ovf;
      string            tag;
   } item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_vld = 1'b0;
   logic [IN_W-1:0] in_data = '0;

   logic             o_vld [NDUT];
   logic [OUT_W-1:0] o_dat [NDUT];
   logic             o_ovf [NDUT];

   item_t            sb [NDUT][$];
   logic [OUT_W-1:0] last [NDUT];
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // half-even rounding with clipping
   fxp_requant #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP_LSB(DROP),
                 .RND_MODE(RND_HALF_EVEN), .MSB_MODE(MSB_CLIP)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .out_vld(o_vld[0]), .out_data(o_dat[0]), .out_ovf(o_ovf[0]));

   // half-away rounding with wrapping
   fxp_requant #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP_LSB(DROP),
                 .RND_MODE(RND_HALF_AWAY), .MSB_MODE(MSB_WRAP)) u_dut_aw (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .out_vld(o_vld[1]), .out_data(o_dat[1]), .out_ovf(o_ovf[1]));

   // floor with clipping
   fxp_requant #(.IN_W(IN_W), .OUT_W(OUT_W), .DROP_LSB(DROP),
                 .RND_MODE(RND_FLOOR), .MSB_MODE(MSB_CLIP)) u_dut_fc (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .out_vld(o_vld[2]), .out_data(o_dat[2]), .out_ovf(o_ovf[2]));

   function automatic item_t model(int x, int k, string extra);
      item_t it;
      int q, rem, r, lo, hi;
      q   = x >>> DROP;
      rem = x - q * (1 << DROP);
      r   = q;
      if (k == 0) begin           // R4 half to even
         if (rem > 4 || (rem == 4 && (q % 2 != 0))) r = q + 1;
      end else if (k == 1) begin  // R3 half away from zero
         if (rem > 4 || (rem == 4 && x >= 0)) r = q + 1;
      end                         // k == 2: R2 floor
      lo = -(1 << (OUT_W-1));
      hi = (1 << (OUT_W-1)) - 1;
      it.ovf = (r < lo || r > hi);
      if (k == 1) begin           // R5 wrap
         it.data = r[OUT_W-1:0];
      end else begin              // R6 clip
         if (r > hi) r = hi;
         if (r < lo) r = lo;
         it.data = r[OUT_W-1:0];
      end
      it.tag = (k == 0) ? {"R4 R6", extra} : (k == 1) ? {"R3 R5", extra} : {"R2 R6", extra};
      return it;
   endfunction

   task automatic send(int x, string extra = "");
      @(posedge clk);
      #1;
      in_vld  = 1'b1;
      in_data = x[IN_W-1:0];
      for (int k = 0; k < NDUT; k++) sb[k].push_back(model(x, k, extra));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         in_vld = 1'b0;
      end
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < NDUT; k++) begin
            if (o_vld[k]) begin
               if (sb[k].size() == 0) begin
                  check(1'b0, "R1 unexpected out_vld", 1, 0);
               end else begin
                  item_t e;
                  e = sb[k].pop_front();
                  check(o_dat[k] == e.data, e.tag, int'($signed(o_dat[k])), int'($signed(e.data)));
                  check(o_ovf[k] == e.ovf, {"R7 ", e.tag}, int'(o_ovf[k]), int'(e.ovf));
                  last[k] = o_dat[k];
               end
            end else begin
               check(o_dat[k] == last[k], "R10 hold", int'(o_dat[k]), int'(last[k]));
               check(o_ovf[k] == 1'b0, "R7 idle ovf", int'(o_ovf[k]), 0);
            end
         end
      end
   end

   initial begin
      for (int k = 0; k < NDUT; k++) last[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < NDUT; k++) begin
         check(!o_vld[k] && !o_ovf[k] && o_dat[k] == '0, "R9 reset",
               int'(o_vld[k]) + int'(o_ovf[k]) + int'(o_dat[k]), 0);
      end
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      idle(2);
      // exact halves of both signs (R3, R4)
      send(-12); send(-4); send(4); send(12); send(20); send(-20);
      // floor cases (R2)
      send(-5); send(5); send(-1); send(0);
      idle(2);
      // range edges and round-up overflow (R5, R6, R8)
      send(59); send(60, " R8"); send(511, " R8"); send(-512);
      send(64); send(-64); send(-68); send(-60);
      idle(3);
      // full sweep with gaps
      for (int x = -(1 << (IN_W-1)); x < (1 << (IN_W-1)); x++) begin
         send(x);
         if ((x & 7) == 3) idle(2);
      end
      idle(4);
      for (int k = 0; k < NDUT; k++) begin
         check(sb[k].size() == 0, "R1 missing outputs", sb[k].size(), 0);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule